// File: doc/BRIEF.md
# Radix-4 Pipelined Signed Multiplier

This block multiplies two N-bit two's-complement numbers and returns the full 2N-bit signed product. The operand `in_b` is cut into 2-bit digits. For each digit a 4-to-1 multiplexer picks one of a small set of multiples of `in_a`. The tripled multiple is built once, from a single shift-and-add, and every multiplexer shares it.

Each selected multiple is moved to the weight of its digit by a fixed wire shift. The aligned terms are then summed in a binary adder tree with one register stage per level. Every digit except the highest is treated as unsigned. The highest digit carries the sign of `in_b`, so it selects negated multiples, and the negation is done at the leaf by inverting and adding one.

The block accepts a new operand pair on every clock. Each result is tagged by `out_valid` after a fixed latency, and results leave in the order their operands arrived. There is no back-pressure.

Top module: `r4m_mult`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the exact signed product of the `in_a` and `in_b` values that were sampled with `in_valid` high, as a 2N-bit two's-complement number.
- R2: The latency is LAT = 1 + ceil(log2(N/2)) rising edges, which is 4 for N = 16. The edge that samples the operands counts as the first. `out_valid` is high right after the LAT-th edge and only then.
- R3: For every digit of `in_b` below the top one, digit values 0, 1, 2 and 3 add 0, 1, 2 or 3 times `in_a`, at weight 4^k for digit k.
- R4: The top digit `in_b[N-1:N-2]` is signed. The codes 00, 01, 10 and 11 contribute 0, +1, -2 and -1 times `in_a`, at weight 4^(N/2-1).
- R5: The adder tree output equals the sum of all the aligned partial products that entered it ceil(log2(N/2)) cycles earlier, taken modulo 2^(2N).
- R6: A new operand pair is accepted on every clock. Back-to-back inputs give back-to-back results in the same order.
- R7: A synchronous reset, `rst` high at a rising edge, clears `out_valid`. `out_valid` stays low until an accepted input has travelled the whole pipeline.
- R8: The corner cases hold. Both operands at the most negative value give +2^(2N-2). A zero operand gives 0. An operand of -1 gives the negation of the other operand.
- R9: A cycle with `in_valid` low produces no result. Gaps in the input stream appear as gaps of the same length in `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks an operand pair to be multiplied |
| in_a | input | N | Multiplicand, two's complement |
| in_b | input | N | Multiplier, two's complement, split into 2-bit digits |
| out_valid | output | 1 | Marks a valid product |
| out_prod | output | 2N | Signed product |

## Verification
The digit-stage and tree-sum assertions check the datapath registers on every clock, whatever the state of `in_valid`. They therefore assume that `in_a` and `in_b` always hold defined values. To meet this, the bench drives zeros on both operands whenever it has no pair to send.

The latency and product assertions at the top assume that `in_valid` is low while `rst` is high. They also count only the cycles after reset is released, so the bench holds `in_valid` low throughout reset. The stimulus includes every top-digit code, every lower-digit value, the extreme operand values, long back-to-back runs and streams with gaps.

// File: rtl/r4m_pkg.sv
package r4m_pkg;
   // number of adder tree levels needed to reduce n leaves to one
   function automatic int unsigned tree_depth(input int unsigned n);
      int unsigned d;
      d = 0;
      while ((1 << d) < n) d++;
      return d;
   endfunction

   // digit count of an N-bit multiplier in radix 4
   function automatic int unsigned digit_count(input int unsigned n);
      return n / 2;
   endfunction
endpackage

// File: rtl/r4m_multiples.sv
// Sign-extends the multiplicand to the product width and forms 1x, 2x, 3x.
module r4m_multiples #(
   parameter int unsigned N = 16,
   localparam int unsigned W = 2 * N
) (
   input  logic [N-1:0] a,
   output logic [W-1:0] m1,
   output logic [W-1:0] m2,
   output logic [W-1:0] m3
);
   always_comb begin
      m1 = {{N{a[N-1]}}, a};
      m2 = {m1[W-2:0], 1'b0};
      m3 = m1 + m2;            // single shared adder for the tripled multiple
   end
endmodule

// File: rtl/r4m_digit_sel.sv
// One radix-4 digit: 4-to-1 multiple select, wiring shift, register.
module r4m_digit_sel #(
   parameter int unsigned W     = 32,
   parameter int unsigned SHIFT = 0,
   parameter bit          IS_TOP = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   dig,
   input  logic [W-1:0] m1,
   input  logic [W-1:0] m2,
   input  logic [W-1:0] m3,
   output logic [W-1:0] pp_q
);
   logic [W-1:0] sel;
   logic [W-1:0] aligned;

   generate
      if (IS_TOP) begin : g_signed
         always_comb begin
            unique case (dig)
               2'b00: sel = '0;
               2'b01: sel = m1;
               2'b10: sel = ~m2 + W'(1);
               default: sel = ~m1 + W'(1);
            endcase
         end
      end else begin : g_unsigned
         always_comb begin
            unique case (dig)
               2'b00: sel = '0;
               2'b01: sel = m1;
               2'b10: sel = m2;
               default: sel = m3;
            endcase
         end
      end
   endgenerate

   assign aligned = sel << SHIFT;

   always_ff @(posedge clk) pp_q <= aligned;

   // assertion support: a clock has passed since reset
   logic primed;
   always_ff @(posedge clk) begin
      if (rst) primed <= 1'b0;
      else     primed <= 1'b1;
   end

   generate
      if (IS_TOP) begin : g_chk_top
         logic [W-1:0] ref_top;
         always_comb begin
            case (dig)
               2'b01:   ref_top = m1 << SHIFT;
               2'b10:   ref_top = W'(0 - (m1 << (SHIFT + 1)));
               2'b11:   ref_top = W'(0 - (m1 << SHIFT));
               default: ref_top = '0;
            endcase
         end
         a_r4_top_digit: assert property (@(posedge clk) disable iff (rst)
            primed |-> pp_q == $past(ref_top));
      end else begin : g_chk_low
         logic [W-1:0] ref_low;
         assign ref_low = W'(m1 * {{(W-2){1'b0}}, dig}) << SHIFT;
         a_r3_low_digit: assert property (@(posedge clk) disable iff (rst)
            primed |-> pp_q == $past(ref_low));
      end
   endgenerate
endmodule

// File: rtl/r4m_add_tree.sv
// Pipelined binary adder tree, heap-indexed, one register per level.
module r4m_add_tree #(
   parameter int unsigned NUM = 8,
   parameter int unsigned W   = 32,
   localparam int unsigned LEVELS = r4m_pkg::tree_depth(NUM),
   localparam int unsigned P      = 1 << LEVELS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM-1:0][W-1:0]   leaves,
   output logic [W-1:0]            sum
);
   logic [W-1:0] leaf [P];
   logic [W-1:0] acc  [P-1];
   logic [W-1:0] node [2*P-1];

   generate
      for (genvar j = 0; j < P; j++) begin : g_leaf
         if (j < NUM) begin : g_used
            assign leaf[j] = leaves[j];
         end else begin : g_pad
            assign leaf[j] = '0;
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < P - 1; i++) node[i] = acc[i];
      for (int j = 0; j < P; j++)     node[P - 1 + j] = leaf[j];
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < P - 1; i++) acc[i] <= node[2*i + 1] + node[2*i + 2];
   end

   assign sum = node[0];

   // assertion support: total of the leaves, and edges since reset
   logic [W-1:0] leaf_total;
   always_comb begin
      leaf_total = '0;
      for (int j = 0; j < NUM; j++) leaf_total = leaf_total + leaves[j];
   end

   logic [7:0] settle;
   always_ff @(posedge clk) begin
      if (rst)                   settle <= '0;
      else if (settle < 8'(LEVELS)) settle <= settle + 8'd1;
   end

   a_r5_tree_sum: assert property (@(posedge clk) disable iff (rst)
      settle >= 8'(LEVELS) |-> sum == $past(leaf_total, LEVELS));
endmodule

// File: rtl/r4m_mult.sv
module r4m_mult #(
   parameter int unsigned N = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [N-1:0]     in_a,
   input  logic [N-1:0]     in_b,
   output logic             out_valid,
   output logic [2*N-1:0]   out_prod
);
   localparam int unsigned W      = 2 * N;
   localparam int unsigned D      = r4m_pkg::digit_count(N);
   localparam int unsigned LEVELS = r4m_pkg::tree_depth(D);
   localparam int unsigned LAT    = 1 + LEVELS;

   generate
      if (N < 4 || (N % 2) != 0) begin : g_bad_width
         $error("r4m_mult: N must be even and at least 4");
      end
   endgenerate

   logic [W-1:0] m1, m2, m3;
   logic [D-1:0][W-1:0] pp;

   r4m_multiples #(.N(N)) u_mult (
      .a  (in_a),
      .m1 (m1),
      .m2 (m2),
      .m3 (m3)
   );

   generate
      for (genvar k = 0; k < D; k++) begin : g_dig
         r4m_digit_sel #(
            .W      (W),
            .SHIFT  (2 * k),
            .IS_TOP (k == D - 1)
         ) u_sel (
            .clk  (clk),
            .rst  (rst),
            .dig  (in_b[2*k +: 2]),
            .m1   (m1),
            .m2   (m2),
            .m3   (m3),
            .pp_q (pp[k])
         );
      end
   endgenerate

   r4m_add_tree #(.NUM(D), .W(W)) u_tree (
      .clk    (clk),
      .rst    (rst),
      .leaves (pp),
      .sum    (out_prod)
   );

   logic [LAT-1:0] vpipe;
   always_ff @(posedge clk) begin
      if (rst) vpipe <= '0;
      else     vpipe <= {vpipe[LAT-2:0], in_valid};
   end
   assign out_valid = vpipe[LAT-1];

   // assertion support
   logic [7:0] settle;
   always_ff @(posedge clk) begin
      if (rst)                   settle <= '0;
      else if (settle < 8'(LAT)) settle <= settle + 8'd1;
   end

   logic signed [W-1:0] ref_prod;
   assign ref_prod = $signed(in_a) * $signed(in_b);

   a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
      settle >= 8'(LAT) |-> out_valid == $past(in_valid, LAT));
   a_r1_product: assert property (@(posedge clk) disable iff (rst)
      (settle >= 8'(LAT) && out_valid) |-> out_prod == $past(ref_prod, LAT));
   a_r7_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> !out_valid);
endmodule

// File: tb/sim_r4m_mult.sv
module sim_r4m_mult;
   localparam int N   = 16;
   localparam int W   = 2 * N;
   localparam int LAT = 1 + $clog2(N / 2);   // from R2

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [N-1:0] in_a = '0;
   logic [N-1:0] in_b = '0;
   logic out_valid;
   logic [W-1:0] out_prod;

   always #4 clk = ~clk;   // 125 MHz

   r4m_mult #(.N(N)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_prod(out_prod)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   logic [W-1:0] exp_val [$];
   int           exp_cyc [$];
   logic [W-1:0] got_val [$];
   int           got_cyc [$];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!rst && out_valid) begin
         got_val.push_back(out_prod);
         got_cyc.push_back(cyc);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic send(input logic [N-1:0] a, input logic [N-1:0] b);
      logic signed [W-1:0] p;
      @(negedge clk);
      in_valid = 1'b1;
      in_a = a;
      in_b = b;
      p = $signed(a) * $signed(b);
      exp_val.push_back(p);
      exp_cyc.push_back(cyc + LAT);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_a = '0;
         in_b = '0;
      end
   endtask

   task automatic drain(input string req);
      idle(LAT + 3);
      chk(got_val.size() == exp_val.size(), "R9", {req, " result count"},
          got_val.size(), exp_val.size());
      while (exp_val.size() > 0 && got_val.size() > 0) begin
         logic [W-1:0] e, g;
         int ec, gc;
         e = exp_val.pop_front();  g = got_val.pop_front();
         ec = exp_cyc.pop_front(); gc = got_cyc.pop_front();
         chk(g == e, req, "product R1", longint'($signed(g)), longint'($signed(e)));
         chk(gc == ec, "R2", "result cycle", gc, ec);
      end
      exp_val.delete(); exp_cyc.delete(); got_val.delete(); got_cyc.delete();
   endtask

   task automatic t_reset();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
      end
      rst = 1'b0;
      idle(LAT + 1);
      chk(out_valid == 1'b0, "R7", "out_valid idle after reset", out_valid, 0);
   endtask

   task automatic t_low_digits();   // R3: every value in lower digits
      send(16'd1234, 16'h001B);
      send(16'hF00D, 16'h0E4E);
      send(16'd7,    16'h3FFF);
      send(16'h8001, 16'h1234);
      idle(1);
      drain("R3");
   endtask

   task automatic t_top_digit();    // R4: top digit codes 00,01,10,11
      send(16'd77, 16'h0001);
      send(16'd77, 16'h4000);
      send(16'd77, 16'h8000);
      send(16'd77, 16'hC000);
      send(16'hFFB3, 16'hC000);
      send(16'h7FFF, 16'h8000);
      idle(1);
      drain("R4");
   endtask

   task automatic t_corners();      // R8
      send(16'h8000, 16'h8000);
      send(16'h0000, 16'h5A5A);
      send(16'h5A5A, 16'h0000);
      send(16'hFFFF, 16'h1234);
      send(16'h4321, 16'hFFFF);
      send(16'hFFFF, 16'h8000);
      send(16'h7FFF, 16'h7FFF);
      idle(1);
      drain("R8");
   endtask

   task automatic t_stream();       // R6 and R5: back-to-back pseudo-random
      logic [15:0] s1, s2;
      s1 = 16'hACE1; s2 = 16'h1D2B;
      for (int i = 0; i < 40; i++) begin
         s1 = {s1[14:0], s1[15] ^ s1[13] ^ s1[12] ^ s1[10]};
         s2 = {s2[14:0], s2[15] ^ s2[13] ^ s2[12] ^ s2[10]};
         send(s1, s2);
      end
      idle(1);
      drain("R6");
   endtask

   task automatic t_gaps();         // R9: gaps preserved
      send(16'd3, 16'd5);
      idle(2);
      send(16'hFFFE, 16'd9);
      idle(1);
      send(16'd100, 16'hFF00);
      send(16'd11, 16'd13);
      idle(3);
      send(16'h8000, 16'd1);
      idle(1);
      drain("R9");
   endtask

   initial begin
      t_reset();
      t_low_digits();
      t_top_digit();
      t_corners();
      t_stream();
      t_gaps();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule